// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (2 Kbit)

This block is a synthesizable behavioural model of a 2 Kbit serial EEPROM that is reached over a three-wire link: chip select, a serial clock and serial data in, with a separately enabled serial data out. The organization select input chooses between 128 sixteen-bit words and 256 eight-bit bytes. The model runs from a free-running system clock. It samples the serial pins on that clock and detects rising edges of the serial clock itself. The array lives in two byte-wide lanes that block RAM can hold.

A host raises chip select and sends a start bit, a two-bit operation code and an address field. When the operation needs it, data follows. Reads stream data back and can run on across addresses. Erase and program operations are armed by the frame and begin their self-timed cycle when chip select falls. While that cycle runs, the data-out pin reports busy or ready whenever chip select is high. A write-enable latch guards every operation that changes the array.

Top module: `eep_serial_mem`

## Requirements
- R1: With chip select high, data in is sampled on each serial clock rising edge. Zeros are discarded, and the first 1 is taken as the start bit.
- R2: The two bits after the start bit select the operation: 10 read, 01 write, 11 erase. Code 00 is qualified by the two highest address-field bits: 11 sets the write-enable latch, 00 clears it, 10 erases the whole array and 01 writes the whole array.
- R3: With org = 1 the address field is 8 bits and data is 16 bits. With org = 0 the address field is 9 bits and data is 8 bits. The top bit of the address field is ignored in both modes. In byte mode, byte 2n is the high half of word n and byte 2n+1 is its low half.
- R4: A read drives a single 0 after the last address bit. It then shifts out the addressed item MSB first, with data out changing after each serial clock rising edge.
- R5: While chip select stays high, a read continues with the next address and inserts no extra 0. It wraps from the last word (127) or the last byte (255) to 0.
- R6: Reset clears the write-enable latch. While the latch is clear, write, erase, erase-all and write-all leave the array unchanged and start no cycle. Reads are never blocked.
- R7: Erase sets the addressed item to all ones. Write replaces the item with the given data, whatever it held before.
- R8: Erase-all sets every location to all ones. Write-all stores the given data in every location.
- R9: A program cycle starts on the fall of chip select that follows the last bit of an accepted frame. If another serial clock rising edge arrives first, the instruction is dropped.
- R10: During a program cycle, chip select high makes data out drive 0 while busy and 1 once the cycle is done. Serial input during the cycle is ignored.
- R11: Before any program cycle, every location reads as all ones.
- R12: Data out is disabled whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also times the program cycle |
| rst | input | 1 | Synchronous active-high reset |
| org | input | 1 | Organization select: 1 = 16-bit words, 0 = bytes |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (read data or busy/ready) |
| sdo_oe | output | 1 | Output enable for sdo; low means high-impedance |

## Verification
The bench reads across the top of the array in both organizations. A pointer that does not wrap, or that inserts a second zero, shifts every later item. It sets an undecoded top address bit and checks that the write lands on the aliased location, and it checks in word mode a byte written in byte mode, which catches a wrong lane mapping. It also sends a frame with one extra clock edge before chip select falls, and sends write frames while the enable latch is clear, both before the latch is first set and after a reset. A design that armed too eagerly would then show busy on data out and corrupt data that is read back afterwards. It toggles junk frames during each busy period, so a front end that listened while busy would change the array or never report ready.

// File: rtl/eep_pkg.sv
package eep_pkg;

  typedef enum logic [2:0] {
    OP_READ, OP_WRITE, OP_ERASE, OP_EWEN, OP_EWDS, OP_ERAL, OP_WRAL
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HUNT, S_COLLECT, S_READ, S_ARMED, S_IGNORE, S_BUSY, S_STAT
  } st_e;

  // Map the primary code and the extension bits to an operation.
  function automatic op_e decode_op(input logic [1:0] opc, input logic [1:0] ext);
    op_e r;
    case (opc)
      2'b10:   r = OP_READ;
      2'b01:   r = OP_WRITE;
      2'b11:   r = OP_ERASE;
      default: begin
        case (ext)
          2'b11:   r = OP_EWEN;
          2'b00:   r = OP_EWDS;
          2'b10:   r = OP_ERAL;
          default: r = OP_WRAL;
        endcase
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/eep_lane.sv
module eep_lane #(
  parameter int AW = 7,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int TICKS = 250000
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  output logic                           busy,
  output logic [$clog2(TICKS+1)-1:0]     idx,
  output logic                           done
);
  localparam int TW = $clog2(TICKS + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (idx == TW'(TICKS - 1)) busy <= 1'b0;
      else idx <= idx + TW'(1);
    end
  end

  assign done = busy && (idx == TW'(TICKS - 1));

  // R9: a new cycle is only launched when none is running
  a_r9_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  // R9: the cycle begins right after the launching edge
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && idx == '0));
endmodule

// File: rtl/eep_serial_mem.sv
module eep_serial_mem #(
  parameter int ADDR_W     = 7,
  parameter int LANE_W     = 8,
  parameter int PROG_TICKS = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic org,
  input  logic cs,
  input  logic sck,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe
);
  import eep_pkg::*;

  localparam int WORDS = 1 << ADDR_W;
  localparam int AW_W  = ADDR_W + 1;
  localparam int AW_B  = ADDR_W + 2;
  localparam int DW_W  = 2 * LANE_W;
  localparam int DW_B  = LANE_W;
  localparam int SRW   = (2 + AW_B > DW_W) ? 2 + AW_B : DW_W;
  localparam int FULL  = 2 + AW_W + DW_W;
  localparam int CNW   = $clog2(FULL + 1);
  localparam int BW    = $clog2(DW_W);
  localparam int PW    = ADDR_W + 1;
  localparam int TW    = $clog2(PROG_TICKS + 1);

  st_e             st;
  op_e             op_q;
  logic            cs_q, sck_q, wen, sdo_q, oe_q;
  logic [CNW-1:0]  cnt;
  logic [SRW-2:0]  sr;
  logic [PW-1:0]   ptr;
  logic [DW_W-1:0] pdata;
  logic [BW-1:0]   bidx;

  // front-end decode
  logic            rise, cs_fall, prog_start;
  logic [SRW-1:0]  nxt;
  logic [CNW-1:0]  cnt_n, aw_len, full_len;
  logic [1:0]      opc, ext;
  op_e             dec_op;
  logic [PW-1:0]   ptr_n, ptr_inc;
  logic [DW_W-1:0] data_n, rword, wd;
  logic [BW-1:0]   dw_top;

  assign rise       = cs & sck & ~sck_q;
  assign cs_fall    = cs_q & ~cs;
  assign prog_start = (st == S_ARMED) && cs_fall && wen;
  assign nxt        = {sr, sdi};
  assign cnt_n      = cnt + CNW'(1);
  assign aw_len     = org ? CNW'(2 + AW_W) : CNW'(2 + AW_B);
  assign full_len   = org ? CNW'(2 + AW_W + DW_W) : CNW'(2 + AW_B + DW_B);
  assign opc        = org ? nxt[AW_W+1:AW_W] : nxt[AW_B+1:AW_B];
  assign ext        = org ? nxt[AW_W-1:AW_W-2] : nxt[AW_B-1:AW_B-2];
  assign dec_op     = decode_op(opc, ext);
  assign ptr_n      = org ? {1'b0, nxt[ADDR_W-1:0]} : nxt[ADDR_W:0];
  assign ptr_inc    = org ? {1'b0, ptr[ADDR_W-1:0] + ADDR_W'(1)} : ptr + PW'(1);
  assign data_n     = org ? nxt[DW_W-1:0] : {{LANE_W{1'b0}}, nxt[LANE_W-1:0]};
  assign dw_top     = org ? BW'(DW_W - 1) : BW'(DW_B - 1);

  // program timer and array lanes (index 1 = high byte, 0 = low byte)
  logic          t_busy, t_done, bulk, we_any;
  logic [TW-1:0] t_idx;
  logic [1:0]    lane_en, lane_we;
  logic [ADDR_W-1:0] wptr, waddr;
  logic [LANE_W-1:0] rd [2];

  eep_prog_timer #(.TICKS(PROG_TICKS)) i_timer (
    .clk(clk), .rst(rst), .start(prog_start),
    .busy(t_busy), .idx(t_idx), .done(t_done)
  );

  assign bulk       = (op_q == OP_ERAL) || (op_q == OP_WRAL);
  assign wptr       = org ? ptr[ADDR_W-1:0] : ptr[ADDR_W:1];
  assign waddr      = bulk ? t_idx[ADDR_W-1:0] : wptr;
  assign we_any     = t_busy && (bulk ? (t_idx < TW'(WORDS)) : (t_idx == '0));
  assign lane_en[1] = org || bulk || !ptr[0];
  assign lane_en[0] = org || bulk || ptr[0];
  assign lane_we    = lane_en & {2{we_any}};
  assign wd = ((op_q == OP_WRITE) || (op_q == OP_WRAL))
            ? (org ? pdata : {pdata[LANE_W-1:0], pdata[LANE_W-1:0]})
            : '1;
  assign rword = org ? {rd[1], rd[0]}
                     : {{LANE_W{1'b0}}, (ptr[0] ? rd[0] : rd[1])};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    eep_lane #(.AW(ADDR_W), .W(LANE_W)) i_lane (
      .clk(clk), .we(lane_we[g]), .waddr(waddr),
      .wdata(wd[g*LANE_W +: LANE_W]), .raddr(wptr), .rdata(rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      op_q  <= OP_READ;
      cs_q  <= 1'b0;
      sck_q <= 1'b0;
      wen   <= 1'b0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
      cnt   <= '0;
      sr    <= '0;
      ptr   <= '0;
      pdata <= '0;
      bidx  <= '0;
    end else begin
      cs_q  <= cs;
      sck_q <= sck;
      case (st)
        S_BUSY: begin
          oe_q  <= cs;
          sdo_q <= t_done;
          if (t_done) st <= S_STAT;
        end
        S_STAT: begin
          if (!cs) begin
            st   <= S_IDLE;
            oe_q <= 1'b0;
          end else begin
            oe_q  <= 1'b1;
            sdo_q <= 1'b1;
          end
        end
        default: begin
          if (!cs) begin
            oe_q  <= 1'b0;
            sdo_q <= 1'b0;
            st    <= prog_start ? S_BUSY : S_IDLE;
          end else begin
            case (st)
              S_IDLE: st <= S_HUNT;
              S_HUNT: begin
                if (rise && sdi) begin
                  st  <= S_COLLECT;
                  cnt <= '0;
                  sr  <= '0;
                end
              end
              S_COLLECT: begin
                if (rise) begin
                  sr  <= nxt[SRW-2:0];
                  cnt <= cnt_n;
                  if (cnt_n == aw_len) begin
                    op_q <= dec_op;
                    ptr  <= ptr_n;
                    case (dec_op)
                      OP_READ: begin
                        st    <= S_READ;
                        oe_q  <= 1'b1;
                        sdo_q <= 1'b0;
                        bidx  <= dw_top;
                      end
                      OP_EWEN:  begin wen <= 1'b1; st <= S_IGNORE; end
                      OP_EWDS:  begin wen <= 1'b0; st <= S_IGNORE; end
                      OP_ERASE, OP_ERAL: st <= S_ARMED;
                      default: ;
                    endcase
                  end else if (cnt_n == full_len) begin
                    pdata <= data_n;
                    st    <= S_ARMED;
                  end
                end
              end
              S_READ: begin
                if (rise) begin
                  sdo_q <= rword[bidx];
                  if (bidx == '0) begin
                    bidx <= dw_top;
                    ptr  <= ptr_inc;
                  end else begin
                    bidx <= bidx - BW'(1);
                  end
                end
              end
              S_ARMED: if (rise) st <= S_IGNORE;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign sdo    = sdo_q;
  assign sdo_oe = oe_q;

  // R12: deselecting the device releases the output
  a_r12_hiz_when_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !sdo_oe);
  // R10: busy is reported as a driven 0 while selected
  a_r10_busy_drives_low: assert property (@(posedge clk) disable iff (rst)
    (st == S_BUSY && cs && !t_done) |=> (sdo_oe && !sdo));
  // R4: entering a read presents the leading 0
  a_r4_dummy_zero: assert property (@(posedge clk) disable iff (rst)
    (st == S_READ && $past(st) != S_READ) |-> (sdo_oe && !sdo));
  // R6: a read never modifies the array
  a_r6_read_no_write: assert property (@(posedge clk) disable iff (rst)
    (st == S_READ) |-> (lane_we == 2'b00));
endmodule

// File: tb/test_eep_serial_mem.sv
module test_eep_serial_mem;
  localparam int TICKS = 300;

  logic clk = 1'b0, rst = 1'b1, org = 1'b1, cs = 1'b0, sck = 1'b0, sdi = 1'b0;
  wire  sdo, sdo_oe;

  always #10 clk = ~clk;

  eep_serial_mem #(.ADDR_W(7), .LANE_W(8), .PROG_TICKS(TICKS)) i_eep_serial_mem (
    .clk(clk), .rst(rst), .org(org), .cs(cs), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  typedef struct { logic [15:0] val; string tag; } exp_t;

  int          n_chk = 0, n_err = 0;
  bit          finished = 1'b0;
  logic [7:0]  ref_b [256];
  exp_t        exp_q [$];
  logic [15:0] act_w;
  event        got_w;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare every completed read item with the scoreboard
  initial begin
    forever begin
      @(got_w);
      begin
        exp_t e;
        if (exp_q.size() == 0) check(1'b0, "scoreboard underflow", act_w, 16'h0);
        else begin
          e = exp_q.pop_front();
          check(act_w === e.val, e.tag, act_w, e.val);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int aw();
    return org ? 8 : 9;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  task automatic xfer(input logic b, output logic q);
    sdi = b;
    step(3);
    sck = 1'b1;
    step(4);
    q   = sdo;
    sck = 1'b0;
    step(3);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      logic q;
      xfer(v[i], q);
    end
  endtask

  task automatic sel();
    step(1);
    cs = 1'b1;
    step(3);
  endtask

  task automatic desel();
    cs  = 1'b0;
    sdi = 1'b0;
    step(4);
  endtask

  task automatic set_word(input int w, input logic [15:0] d);
    ref_b[2*w]   = d[15:8];
    ref_b[2*w+1] = d[7:0];
  endtask

  // read n items starting at field a, with 'lead' zeros before the start bit
  task automatic rd(input logic [31:0] a, input int n, input int lead, input string tag);
    logic q;
    logic [15:0] v;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      if (org) begin
        int w;
        w = (int'(a[6:0]) + k) % 128;
        e.val = {ref_b[2*w], ref_b[2*w+1]};
      end else begin
        int b;
        b = (int'(a[7:0]) + k) % 256;
        e.val = {8'h00, ref_b[b]};
      end
      e.tag = tag;
      exp_q.push_back(e);
    end
    sel();
    if (lead > 0) send(32'h0, lead);
    send(32'h1, 1);
    send(32'h2, 2);
    send(a >> 1, aw() - 1);
    xfer(a[0], q);
    check(q === 1'b0 && sdo_oe === 1'b1, {tag, " R4 leading zero"}, 16'({sdo_oe, q}), 16'h2);
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int i = 0; i < dw(); i++) begin
        xfer(1'b0, q);
        v = {v[14:0], q};
      end
      act_w = v;
      -> got_w;
      step(1);
    end
    desel();
  endtask

  task automatic ext_cmd(input logic [1:0] e);
    sel();
    send(32'h1, 1);
    send(32'h0, 2);
    send(32'(e) << (aw() - 2), aw());
    desel();
  endtask

  // erase/write frame followed by a status poll
  task automatic prog(input logic [1:0] op, input logic [31:0] field, input logic [15:0] data,
                      input bit has_data, input bit extra, input bit ok, input string tag);
    logic q;
    sel();
    send(32'h1, 1);
    send(32'(op), 2);
    send(field, aw());
    if (has_data) send(32'(data), dw());
    if (extra) xfer(1'b0, q);
    desel();
    sel();
    if (ok) begin
      int t = 0;
      check(sdo_oe === 1'b1 && sdo === 1'b0, {tag, " R10 busy"}, 16'({sdo_oe, sdo}), 16'h2);
      send(32'h0000_0C55, 12);   // junk frame while busy (R10)
      while (sdo !== 1'b1 && t < 3000) begin
        step(1);
        t++;
      end
      check(sdo_oe === 1'b1 && sdo === 1'b1, {tag, " R10 ready"}, 16'({sdo_oe, sdo}), 16'h3);
    end else begin
      step(2);
      check(sdo_oe === 1'b0, {tag, " no cycle started"}, 16'(sdo_oe), 16'h0);
    end
    desel();
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 190000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_b[i] = 8'hFF;
    step(5);
    rst = 1'b0;
    step(2);
    check(sdo_oe === 1'b0, "R12 output off after reset", 16'(sdo_oe), 16'h0);
    sel();
    step(4);
    check(sdo_oe === 1'b0, "R12 selected with no read", 16'(sdo_oe), 16'h0);
    desel();

    // R11 and R1: erased array, start bit after leading zeros
    rd(32'd5, 1, 3, "R11 R1 word 5");
    rd(32'd10, 2, 0, "R11 words 10-11");

    // R6: latch clear after reset blocks writing
    prog(2'b01, 32'd5, 16'h1234, 1'b1, 1'b0, 1'b0, "R6 locked write");
    rd(32'd5, 1, 0, "R6 read while locked");

    // R2: enable, then R7 write
    ext_cmd(2'b11);
    prog(2'b01, 32'd5, 16'hA5C3, 1'b1, 1'b0, 1'b1, "R7 write");
    set_word(5, 16'hA5C3);
    rd(32'd5, 1, 0, "R7 write readback");

    // R3: top address bit ignored in word mode
    prog(2'b01, 32'h86, 16'h0F0F, 1'b1, 1'b0, 1'b1, "R3 aliased write");
    set_word(6, 16'h0F0F);
    rd(32'd6, 1, 0, "R3 alias readback");

    // R5: wrap in word mode
    prog(2'b01, 32'd0, 16'h0001, 1'b1, 1'b0, 1'b1, "R5 prep word 0");
    set_word(0, 16'h0001);
    prog(2'b01, 32'd127, 16'h7F7F, 1'b1, 1'b0, 1'b1, "R5 prep word 127");
    set_word(127, 16'h7F7F);
    rd(32'd126, 4, 0, "R5 word wrap");

    // R7: erase, then overwrite
    prog(2'b11, 32'd5, 16'h0, 1'b0, 1'b0, 1'b1, "R7 erase");
    set_word(5, 16'hFFFF);
    rd(32'd5, 1, 0, "R7 erase readback");
    prog(2'b01, 32'd5, 16'h5A3C, 1'b1, 1'b0, 1'b1, "R7 write over erased");
    prog(2'b01, 32'd5, 16'h1248, 1'b1, 1'b0, 1'b1, "R7 overwrite");
    set_word(5, 16'h1248);
    rd(32'd5, 1, 0, "R7 overwrite readback");

    // R3: byte mode mapping, ignored top bit
    org = 1'b0;
    step(2);
    rd(32'd12, 2, 0, "R3 byte read");
    prog(2'b01, 32'h10D, 16'h003C, 1'b1, 1'b0, 1'b1, "R3 byte write");
    ref_b[13] = 8'h3C;
    rd(32'd12, 2, 0, "R3 byte readback");
    org = 1'b1;
    step(2);
    rd(32'd6, 1, 0, "R3 lane order in word mode");
    org = 1'b0;
    step(2);
    rd(32'd254, 3, 0, "R5 byte wrap");

    // R9: extra clock edge drops the instruction
    prog(2'b01, 32'd20, 16'h0055, 1'b1, 1'b1, 1'b0, "R9 extra edge");
    rd(32'd20, 1, 0, "R9 dropped write readback");

    // R6: disable blocks erase
    ext_cmd(2'b00);
    prog(2'b11, 32'd12, 16'h0, 1'b0, 1'b0, 1'b0, "R6 disabled erase");
    rd(32'd12, 1, 0, "R6 disabled erase readback");

    // R8: write-all in byte mode, erase-all in word mode
    ext_cmd(2'b11);
    prog(2'b00, 32'h080, 16'h005A, 1'b1, 1'b0, 1'b1, "R8 write all");
    for (int i = 0; i < 256; i++) ref_b[i] = 8'h5A;
    rd(32'd0, 2, 0, "R8 write all low");
    rd(32'd200, 1, 0, "R8 write all mid");
    org = 1'b1;
    step(2);
    rd(32'd64, 1, 0, "R8 write all word");
    prog(2'b00, 32'h80, 16'h0, 1'b0, 1'b0, 1'b1, "R8 erase all");
    for (int i = 0; i < 256; i++) ref_b[i] = 8'hFF;
    rd(32'd127, 2, 0, "R8 erase all readback");

    // R6: reset clears the latch
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(2);
    prog(2'b01, 32'd3, 16'h1111, 1'b1, 1'b0, 1'b0, "R6 latch after reset");
    rd(32'd3, 1, 0, "R6 after reset readback");

    step(5);
    check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    report();
  end
endmodule